// File: doc/BRIEF.md
# Out-of-Window Interrupt Filter with Persistence Count

This block watches the stream of 16-bit results from a light-measurement converter and decides when to interrupt the host. Each time the converter finishes a conversion, it presents a result with a one-cycle end-of-conversion strobe. The block compares that result with a programmable low limit and a programmable high limit. It then counts how many results in a row have fallen outside the window. When the count reaches the number selected by a 4-bit persistence code, a latched status bit is raised. The status bit stays raised until the host issues a clear strobe.

The interrupt pin value is the status bit gated by an enable input. The pin is active-low and models an open-drain output: 0 means the pin is pulled down, 1 means it is released. The status bit is updated whether or not the pin is enabled. The limits and the register storage around the block are held elsewhere.

A three-state machine controls the decision:
- `ST_IDLE`: no out-of-window result is pending and the run count is zero.
- `ST_ARMED`: a run of out-of-window results is under way, but the required count has not yet been reached.
- `ST_FIRED`: the status bit is latched.

The transitions are:
- **arm** (`ST_IDLE` → `ST_ARMED`): an out-of-window result arrives and does not yet reach the required count.
- **trip** (`ST_IDLE` or `ST_ARMED` → `ST_FIRED`): the required count is reached, or the persistence code is 0.
- **relax** (`ST_ARMED` → `ST_IDLE`): an in-window result arrives.
- **ack** (any state → `ST_IDLE`): the clear strobe is high.

Top module: `trip_persist_irq`

## Requirements
- R1: A result counts as out of window when it is strictly below the low limit or strictly above the high limit. A result equal to either limit is in the window.
- R2: The low limit is tested first. When the low limit is greater than the high limit, the high-limit test is ignored, and only a result below the low limit counts as out of window.
- R3: With persistence code 0, every completed conversion latches the status bit, whatever the result value.
- R4: Persistence codes 1, 2 and 3 require 1, 2 and 3 consecutive out-of-window results. A code c from 4 to 15 requires 5*(c-3) consecutive results, so code 4 needs 5 and code 15 needs 60.
- R5: An in-window result resets the consecutive count to zero.
- R6: Once latched, the status bit stays at 1 through any further results until the clear strobe is high. The clear then returns it to 0.
- R7: The clear strobe also zeroes the consecutive count. A result whose strobe falls in the same cycle as a clear is discarded.
- R8: The status bit is updated whatever the enable input is. The pin output `irq_n_o` is 0 exactly when the status bit and the enable are both 1, and is 1 otherwise.
- R9: The status bit changes in the cycle after the clock edge that samples the end-of-conversion strobe. After reset, the status bit is 0 and the pin is 1.
- R10: With the end-of-conversion strobe low and the clear strobe low, the status bit holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc_i | input | 1 | One-cycle strobe marking a completed conversion |
| result_i | input | 16 | Conversion result, valid while `eoc_i` is high |
| thr_lo_i | input | 16 | Low window limit |
| thr_hi_i | input | 16 | High window limit |
| pers_code_i | input | 4 | Persistence code |
| irq_en_i | input | 1 | Pin enable |
| clr_i | input | 1 | Clear strobe for the status bit and the run count |
| status_o | output | 1 | Latched interrupt status |
| irq_n_o | output | 1 | Open-drain pin value, 0 = pulled low |

## Verification
A wrong state or a wrong run count shows at `status_o` one cycle after the conversion that should, or should not, have tripped the filter. It also shows at `irq_n_o` in the same cycle whenever the pin is enabled.

A run count that fails to reset or saturate stays hidden until a later run. The bench therefore clears the block, replays runs one short of, and exactly at, the required length for every code, and interleaves in-window results and clears. A wrong comparison order appears only when the low limit sits above the high limit, so that setting is driven explicitly.

// File: rtl/trip_pkg.sv
package trip_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_FIRED = 2'd2
    } trip_state_e;

    localparam int unsigned LINEAR_CODES = 3;
    localparam int unsigned STEP_LEN     = 5;
endpackage

// File: rtl/trip_window_cmp.sv
module trip_window_cmp #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] thr_lo_i,
    input  logic [DATA_W-1:0] thr_hi_i,
    output logic              out_o
);
    always_comb begin
        if (result_i < thr_lo_i) begin
            out_o = 1'b1;
        end else if (thr_lo_i <= thr_hi_i) begin
            out_o = (result_i > thr_hi_i);
        end else begin
            out_o = 1'b0;
        end
    end
endmodule

// File: rtl/trip_run_counter.sv
module trip_run_counter #(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned MAX   = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             zero_i,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (zero_i) begin
            cnt_o <= '0;
        end else if (inc_i && (cnt_o != CNT_W'(MAX))) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_W'(MAX));
endmodule

// File: rtl/trip_irq_fsm.sv
module trip_irq_fsm
    import trip_pkg::*;
#(
    parameter int unsigned CODE_W = 4,
    parameter int unsigned CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc_i,
    input  logic              clr_i,
    input  logic              out_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              inc_o,
    output logic              zero_o,
    output logic              status_o
);
    trip_state_e st_q, st_d;
    logic [CNT_W:0] need;
    logic [CNT_W:0] cnt_next;

    function automatic logic [CNT_W:0] need_of(input logic [CODE_W-1:0] c);
        int unsigned ci;
        ci = int'(c);
        if (ci <= LINEAR_CODES) begin
            return (CNT_W+1)'(ci);
        end
        return (CNT_W+1)'((ci - LINEAR_CODES) * STEP_LEN);
    endfunction

    assign need     = need_of(code_i);
    assign cnt_next = {1'b0, cnt_i} + 1'b1;

    always_comb begin
        st_d   = st_q;
        inc_o  = 1'b0;
        zero_o = 1'b0;
        if (clr_i) begin
            st_d   = ST_IDLE;
            zero_o = 1'b1;
        end else if (eoc_i) begin
            unique case (st_q)
                ST_IDLE, ST_ARMED: begin
                    if (code_i == '0) begin
                        st_d = ST_FIRED;
                    end else if (out_i) begin
                        inc_o = 1'b1;
                        st_d  = (cnt_next >= need) ? ST_FIRED : ST_ARMED;
                    end else begin
                        zero_o = 1'b1;
                        st_d   = ST_IDLE;
                    end
                end
                ST_FIRED: st_d = ST_FIRED;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        status_o = (st_q == ST_FIRED);
    end

    // R6
    drop_on_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status_o) |-> $past(clr_i));
    // R7
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (cnt_i == '0 && !status_o));
    // R3
    every_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(eoc_i && !clr_i && code_i == '0) |-> status_o);
    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!eoc_i && !clr_i) |-> $stable(status_o));
endmodule

// File: rtl/trip_persist_irq.sv
module trip_persist_irq #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoc_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [DATA_W-1:0] thr_lo_i,
    input  logic [DATA_W-1:0] thr_hi_i,
    input  logic [CODE_W-1:0] pers_code_i,
    input  logic              irq_en_i,
    input  logic              clr_i,
    output logic              status_o,
    output logic              irq_n_o
);
    localparam int unsigned MAX_REQ = ((1 << CODE_W) - 1 - trip_pkg::LINEAR_CODES) * trip_pkg::STEP_LEN;
    localparam int unsigned CNT_W   = $clog2(MAX_REQ + 1);

    logic             out_w;
    logic             inc_w;
    logic             zero_w;
    logic [CNT_W-1:0] cnt_w;

    trip_window_cmp #(.DATA_W(DATA_W)) u_cmp (
        .result_i (result_i),
        .thr_lo_i (thr_lo_i),
        .thr_hi_i (thr_hi_i),
        .out_o    (out_w)
    );

    trip_run_counter #(.CNT_W(CNT_W), .MAX(MAX_REQ)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc_w),
        .zero_i (zero_w),
        .cnt_o  (cnt_w)
    );

    trip_irq_fsm #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .eoc_i    (eoc_i),
        .clr_i    (clr_i),
        .out_i    (out_w),
        .code_i   (pers_code_i),
        .cnt_i    (cnt_w),
        .inc_o    (inc_w),
        .zero_o   (zero_w),
        .status_o (status_o)
    );

    assign irq_n_o = ~(status_o & irq_en_i);

    // R8
    pin_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> status_o);
endmodule

// File: tb/trip_persist_irq_tb.sv
module trip_persist_irq_tb;
    typedef struct packed {
        logic        clr;
        logic [15:0] res;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [3:0]  code;
        logic        en;
        logic        st;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'd3000, 16'd1000, 16'd5000, 4'd1, 1'b1, 1'b0, 4'd1},  // R1 inside
        '{1'b1, 16'd500,  16'd1000, 16'd5000, 4'd1, 1'b1, 1'b1, 4'd1},  // R1 below
        '{1'b1, 16'd6000, 16'd1000, 16'd5000, 4'd1, 1'b0, 1'b1, 4'd8},  // R8 pin gated
        '{1'b1, 16'd3000, 16'd1000, 16'd5000, 4'd0, 1'b1, 1'b1, 4'd3},  // R3
        '{1'b1, 16'd5000, 16'd1000, 16'd5000, 4'd1, 1'b1, 1'b0, 4'd1},  // R1 equal high
        '{1'b1, 16'd1000, 16'd1000, 16'd5000, 4'd1, 1'b1, 1'b0, 4'd1},  // R1 equal low
        '{1'b1, 16'd999,  16'd1000, 16'd5000, 4'd1, 1'b1, 1'b1, 4'd1},
        '{1'b1, 16'd5001, 16'd1000, 16'd5000, 4'd1, 1'b1, 1'b1, 4'd1},
        '{1'b1, 16'd5000, 16'd4000, 16'd2000, 4'd1, 1'b1, 1'b0, 4'd2},  // R2 high ignored
        '{1'b1, 16'd3000, 16'd4000, 16'd2000, 4'd1, 1'b1, 1'b1, 4'd2},  // R2 low decides
        '{1'b1, 16'd500,  16'd1000, 16'd5000, 4'd2, 1'b1, 1'b0, 4'd4},  // R4 code 2
        '{1'b0, 16'd600,  16'd1000, 16'd5000, 4'd2, 1'b1, 1'b1, 4'd4},
        '{1'b1, 16'd500,  16'd1000, 16'd5000, 4'd2, 1'b1, 1'b0, 4'd5},  // R5
        '{1'b0, 16'd3000, 16'd1000, 16'd5000, 4'd2, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'd500,  16'd1000, 16'd5000, 4'd2, 1'b1, 1'b0, 4'd5},
        '{1'b0, 16'd500,  16'd1000, 16'd5000, 4'd2, 1'b1, 1'b1, 4'd5},
        '{1'b0, 16'd3000, 16'd1000, 16'd5000, 4'd2, 1'b1, 1'b1, 4'd6},  // R6 stays latched
        '{1'b1, 16'd500,  16'd1000, 16'd5000, 4'd3, 1'b1, 1'b0, 4'd7},  // R7
        '{1'b1, 16'd500,  16'd1000, 16'd5000, 4'd3, 1'b1, 1'b0, 4'd7},
        '{1'b0, 16'd500,  16'd1000, 16'd5000, 4'd3, 1'b1, 1'b0, 4'd7},
        '{1'b0, 16'd500,  16'd1000, 16'd5000, 4'd3, 1'b1, 1'b1, 4'd7},
        '{1'b1, 16'd9,    16'd1000, 16'd5000, 4'd3, 1'b1, 1'b0, 4'd4},  // R4 code 3
        '{1'b0, 16'd9,    16'd1000, 16'd5000, 4'd3, 1'b1, 1'b0, 4'd4},
        '{1'b0, 16'd9,    16'd1000, 16'd5000, 4'd3, 1'b1, 1'b1, 4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc_i = 1'b0;
    logic [15:0] result_i = '0;
    logic [15:0] thr_lo_i = 16'd1000;
    logic [15:0] thr_hi_i = 16'd5000;
    logic [3:0]  pers_code_i = '0;
    logic        irq_en_i = 1'b1;
    logic        clr_i = 1'b0;
    logic        status_o;
    logic        irq_n_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    trip_persist_irq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .eoc_i       (eoc_i),
        .result_i    (result_i),
        .thr_lo_i    (thr_lo_i),
        .thr_hi_i    (thr_hi_i),
        .pers_code_i (pers_code_i),
        .irq_en_i    (irq_en_i),
        .clr_i       (clr_i),
        .status_o    (status_o),
        .irq_n_o     (irq_n_o)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic conv(input logic [15:0] r);
        @(negedge clk);
        result_i = r;
        eoc_i    = 1'b1;
        @(negedge clk);
        eoc_i    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset status", status_o, 1'b0);
        check("R9 reset pin", irq_n_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].clr) do_clear();
            thr_lo_i    = VECS[i].lo;
            thr_hi_i    = VECS[i].hi;
            pers_code_i = VECS[i].code;
            irq_en_i    = VECS[i].en;
            conv(VECS[i].res);
            check($sformatf("R%0d vec %0d status", VECS[i].req, i), status_o, VECS[i].st);
            check($sformatf("R%0d vec %0d pin", VECS[i].req, i), irq_n_o, ~(VECS[i].st & VECS[i].en));
        end

        // R8: pin follows enable while status held
        irq_en_i = 1'b0;
        #1;
        check("R8 pin released", irq_n_o, 1'b1);
        irq_en_i = 1'b1;
        #1;
        check("R8 pin pulled", irq_n_o, 1'b0);

        // R10: idle cycles keep status
        repeat (5) @(negedge clk);
        check("R10 hold", status_o, 1'b1);

        // R6: clear drops status and releases pin
        do_clear();
        check("R6 cleared status", status_o, 1'b0);
        check("R6 cleared pin", irq_n_o, 1'b1);

        // R7: result with simultaneous clear is discarded
        thr_lo_i = 16'd1000; thr_hi_i = 16'd5000; pers_code_i = 4'd1;
        @(negedge clk);
        result_i = 16'd10; eoc_i = 1'b1; clr_i = 1'b1;
        @(negedge clk);
        eoc_i = 1'b0; clr_i = 1'b0;
        check("R7 same-cycle clear", status_o, 1'b0);

        // R9: status latency exactly one edge
        @(negedge clk);
        result_i = 16'd10; eoc_i = 1'b1;
        #1;
        check("R9 not before edge", status_o, 1'b0);
        @(negedge clk);
        eoc_i = 1'b0;
        check("R9 after edge", status_o, 1'b1);

        // R4: long persistence codes
        for (int c = 4; c < 16; c++) begin
            int need;
            need = (c - 3) * 5;
            do_clear();
            pers_code_i = 4'(c);
            for (int k = 1; k < need; k++) conv(16'd60000);
            check($sformatf("R4 code %0d short run", c), status_o, 1'b0);
            conv(16'd60000);
            check($sformatf("R4 code %0d full run", c), status_o, 1'b1);
        end

        // R5 with a long code: break near the end then restart
        do_clear();
        pers_code_i = 4'd5;
        for (int k = 0; k < 9; k++) conv(16'd60000);
        conv(16'd2000);
        for (int k = 0; k < 9; k++) conv(16'd60000);
        check("R5 broken run", status_o, 1'b0);
        conv(16'd60000);
        check("R5 restarted run", status_o, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule